// File: doc/BRIEF.md
# Auto-Indexed Filter Table Window

This block places a 40-word table of wakeup-frame filter settings behind a single 32-bit register location. Software does not address the table entries one by one. It writes consecutive words to the same location, and an internal write pointer places each word in the next table entry. Reads from the location work the same way, with a separate read pointer. The table is organised as 8 filters of 5 words each. Both pointers wrap to entry 0 after the last entry, so a full pass of 40 accesses leaves each pointer where it started.

If software stops partway through a sequence, a pointer is left mid-table. A one-cycle clear pulse, driven from a bit in a control/status register elsewhere, brings both pointers back to entry 0. The clear pulse leaves the stored words unchanged. The whole table is also presented as one flat vector for the frame-matching logic, which sits outside this block.

Top module: `filt_window`

## Requirements
- R1: After reset, every table entry is zero and the window reads as 0000_0000h. Both pointers are at entry 0.
- R2: Each accepted write (`sel` and `wr_en` high) stores `wdata` in the entry at the write pointer. The write pointer then advances by one on that clock edge. After reset, the first write goes to entry 0.
- R3: The write after the one that fills entry 39 goes to entry 0 again.
- R4: During an accepted read (`sel` and `rd_en` high, `wr_en` low), `rdata` shows the entry at the read pointer in the same cycle. The read pointer advances by one on that clock edge.
- R5: The read after the one that returns entry 39 returns entry 0.
- R6: The read and write pointers are independent. An access of one kind never moves the other pointer.
- R7: A `ptr_clr` pulse with no access returns both pointers to entry 0 at the next clock edge. It leaves the table contents unchanged.
- R8: If `ptr_clr` is high in the same cycle as an accepted access, that access uses entry 0 and its pointer ends at entry 1. The other pointer ends at entry 0.
- R9: If `wr_en` and `rd_en` are both high with `sel`, the write takes effect, `rdata` is zero and the read pointer holds.
- R10: While `sel` is low, `wr_en` and `rd_en` have no effect on the table or on either pointer, and `rdata` is zero.
- R11: `table_flat` carries entry k in bits [32k+31:32k], for k from 0 to 39.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Window selected this cycle |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid during an accepted read |
| ptr_clr | input | 1 | One-cycle pointer clear from the control/status register |
| table_flat | output | 1280 | Whole table, entry k at bits [32k+31:32k] |

## Verification
The hardest state to reach is the one where the two pointers sit at different, non-zero entries. Both pointers move only through whole accesses, and a clear pulse resets them together. To get there, the bench first makes more than 40 writes, which carries the write pointer past the wrap. It then makes more than 40 reads, which leaves the read pointer at a different offset. In that split state it exercises interleaved accesses, collisions with the clear pulse, and simultaneous read and write strobes. A reference model in the bench tracks both pointers and every entry, and `table_flat` exposes the full contents after each step.

// File: rtl/filt_window.sv
module filt_window #(
  parameter int ENTRIES = 40,
  parameter int WIDTH   = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sel,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [WIDTH-1:0]         wdata,
  output logic [WIDTH-1:0]         rdata,
  input  logic                     ptr_clr,
  output logic [ENTRIES*WIDTH-1:0] table_flat
);
  localparam int PW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PW-1:0] LAST = PW'(ENTRIES - 1);

  logic [WIDTH-1:0] mem [ENTRIES];
  logic [PW-1:0]    wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  wire            wr_go  = sel & wr_en;
  wire            rd_go  = sel & rd_en & ~wr_en;
  wire [PW-1:0]   wr_eff = ptr_clr ? '0 : wr_ptr;
  wire [PW-1:0]   rd_eff = ptr_clr ? '0 : rd_ptr;

  assign rdata = rd_go ? mem[rd_eff] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      for (int i = 0; i < ENTRIES; i++) mem[i] <= '0;
    end else begin
      if (wr_go) begin
        mem[wr_eff] <= wdata;
        wr_ptr      <= step(wr_eff);
      end else if (ptr_clr) begin
        wr_ptr <= '0;
      end
      if (rd_go)        rd_ptr <= step(rd_eff);
      else if (ptr_clr) rd_ptr <= '0;
    end
  end

  for (genvar k = 0; k < ENTRIES; k++) begin : g_flat
    assign table_flat[k*WIDTH +: WIDTH] = mem[k];
  end

  p_wr_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ptr <= LAST);
  p_rd_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr <= LAST);
  p_wr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !ptr_clr) |=> wr_ptr == (($past(wr_ptr) == LAST) ? '0 : $past(wr_ptr) + 1'b1));
  p_wr_keeps_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !ptr_clr) |=> $stable(rd_ptr));
  p_clr_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_clr && !sel) |=> (wr_ptr == '0 && rd_ptr == '0 && $stable(table_flat)));
  p_clr_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_clr && wr_go) |=> (wr_ptr == PW'(1) && rd_ptr == '0));
  p_both_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr_en && rd_en && !ptr_clr) |=> $stable(rd_ptr));
  p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel && !ptr_clr) |=> ($stable(table_flat) && $stable(wr_ptr) && $stable(rd_ptr)));
endmodule

// File: tb/filt_window_test.sv
module filt_window_test;
  localparam int N = 40;
  localparam int W = 32;

  logic clk = 0, rst_n = 0, sel = 0, wr_en = 0, rd_en = 0, ptr_clr = 0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;
  logic [N*W-1:0] table_flat;

  int checks = 0, failures = 0;
  logic [W-1:0] m [N];
  int wp = 0, rp = 0;

  filt_window uut (.clk, .rst_n, .sel, .wr_en, .rd_en, .wdata, .rdata, .ptr_clr, .table_flat);

  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_table(input string req);
    int bad = -1;
    checks++;
    for (int k = 0; k < N; k++)
      if (bad < 0 && table_flat[k*W +: W] !== m[k]) bad = k;
    if (bad >= 0) begin
      failures++;
      $display("FAIL %s entry %0d actual=%h expected=%h", req, bad,
               table_flat[bad*W +: W], m[bad]);
    end
  endtask

  task automatic idle();
    sel = 0; wr_en = 0; rd_en = 0; ptr_clr = 0;
  endtask

  task automatic do_write(input logic [W-1:0] d, input logic clr);
    @(negedge clk);
    sel = 1; wr_en = 1; rd_en = 0; wdata = d; ptr_clr = clr;
    if (clr) begin wp = 0; rp = 0; end
    m[wp] = d; wp = (wp + 1) % N;
    @(posedge clk); #1 idle();
  endtask

  task automatic do_read(input string req, input logic clr);
    @(negedge clk);
    sel = 1; rd_en = 1; wr_en = 0; ptr_clr = clr;
    if (clr) begin wp = 0; rp = 0; end
    #2 chk(req, rdata, m[rp]);
    rp = (rp + 1) % N;
    @(posedge clk); #1 idle();
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 rdata idle", rdata, '0);
    chk_table("R1 table zero");
    sel = 1; rd_en = 1;
    #2 chk("R1 first read", rdata, '0);
    sel = 0; rd_en = 0;
  endtask

  task automatic t_fill();
    for (int i = 0; i < N; i++) do_write(32'hA500_0000 + i * 32'h0101, 0);
    chk_table("R2 sequential fill");
    chk("R11 entry 39 slice", table_flat[39*W +: W], 32'hA500_0000 + 39 * 32'h0101);
    for (int i = 0; i < 3; i++) do_write(32'h5A00_0000 | i, 0);
    chk_table("R3 write wrap");
    chk("R11 entry 0 slice", table_flat[W-1:0], 32'h5A00_0000);
  endtask

  task automatic t_read();
    for (int i = 0; i < N; i++) do_read("R4 sequential read", 0);
    for (int i = 0; i < 5; i++) do_read("R5 read wrap", 0);
  endtask

  task automatic t_indep();
    do_write(32'hC0DE_0003, 0);
    chk_table("R6 write at own pointer");
    do_read("R6 read at own pointer", 0);
    do_write(32'hC0DE_0004, 0);
    do_read("R6 interleaved read", 0);
    chk_table("R6 table after interleave");
  endtask

  task automatic t_clr();
    @(negedge clk); ptr_clr = 1; @(posedge clk); #1 idle();
    wp = 0; rp = 0;
    chk_table("R7 contents kept");
    do_read("R7 read from entry 0", 0);
    do_write(32'hBEEF_0000, 0);
    chk_table("R7 write to entry 0");
  endtask

  task automatic t_clr_access();
    do_write(32'h1111_2222, 0);
    do_read("R8 setup read", 0);
    do_write(32'h3333_4444, 1);
    do_write(32'h5555_6666, 0);
    chk_table("R8 write with clear uses entry 0 then 1");
    do_read("R8 other pointer at 0", 0);
    do_read("R8 setup read 2", 0);
    do_read("R8 read with clear returns entry 0", 1);
    do_read("R8 next read entry 1", 0);
  endtask

  task automatic t_both();
    @(negedge clk);
    sel = 1; wr_en = 1; rd_en = 1; wdata = 32'hD00D_F00D;
    #2 chk("R9 rdata zero on collision", rdata, '0);
    m[wp] = wdata; wp = (wp + 1) % N;
    @(posedge clk); #1 idle();
    chk_table("R9 write applied");
    do_read("R9 read pointer held", 0);
  endtask

  task automatic t_idle();
    @(negedge clk);
    sel = 0; wr_en = 1; rd_en = 1; wdata = 32'hFFFF_FFFF;
    #2 chk("R10 rdata zero unselected", rdata, '0);
    @(posedge clk); #1;
    @(posedge clk); #1 idle();
    chk_table("R10 table untouched");
    do_read("R10 read pointer untouched", 0);
    do_write(32'h0BAD_CAFE, 0);
    chk_table("R10 write pointer untouched");
  endtask

  initial begin
    for (int k = 0; k < N; k++) m[k] = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_fill();
    t_read();
    t_indep();
    t_clr();
    t_clr_access();
    t_both();
    t_idle();
    repeat (2) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule